// File: doc/BRIEF.md
# Vector Bitwise Logic Unit

This block performs bitwise logic on 128-bit vector operands for a SIMD execution pipe. Each accepted operation reads up to three source values: the old contents of the destination register, a first source and a second source. It produces one 128-bit result with a valid strobe exactly one clock later. The register forms cover the usual two-operand logic functions. They also cover three-operand insert and select functions that merge the first source into the old destination under a mask.

Immediate forms apply OR or clear-bits between the old destination and a pattern built from an 8-bit unsigned constant. The constant is shifted left by a byte multiple inside each 16-bit or 32-bit lane and copied into every lane. Arrangements that name only 64 bits zero the upper half of the result. An illegal combination of operation, arrangement and shift raises an error flag, and the old destination passes through unchanged.

Top module: `vec_logic_unit`

## Requirements
- R1: With `opSel` 0 the result is A AND B, 1 gives A OR B, 2 gives A XOR B, 3 gives A AND NOT B, and 4 gives A OR NOT B, where A is `srcA` and B is `srcB`.
- R2: `opSel` 5 gives (D AND B) OR (A AND NOT B), 6 gives (D AND NOT B) OR (A AND B), and 7 gives (D AND A) OR (NOT D AND B), where D is `srcDst`.
- R3: Arrangement codes 0, 2 and 4 are 64-bit forms and force result bits 127:64 to zero. Codes 1, 3 and 5 are 128-bit forms.
- R4: `opSel` 8 ORs and `opSel` 9 clears, in D, an immediate pattern. With arrangement 2 or 3 the pattern is `imm` shifted left by `shiftAmt` within each of the four 32-bit lanes, and shifts 0, 8, 16 and 24 are legal.
- R5: With arrangement 4 or 5 the immediate pattern is `imm` shifted left by `shiftAmt` within each of the eight 16-bit lanes, and only shifts 0 and 8 are legal.
- R6: An immediate operation with an illegal shift for its lane size sets `outErr` and returns D unchanged across all 128 bits.
- R7: An immediate operation with arrangement 0 or 1, any opcode 10 to 15, or arrangement 6 or 7 sets `outErr` and returns D unchanged.
- R8: `outValid`, `outErr` and `result` appear exactly one clock after `inValid`. A synchronous reset clears `outValid` and `outErr`. Without `inValid`, `outValid` is 0 and `result` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation accepted this cycle |
| opSel | input | 4 | Operation code |
| arrSel | input | 3 | Arrangement code |
| srcDst | input | 128 | Old destination value D |
| srcA | input | 128 | First source A |
| srcB | input | 128 | Second source B |
| imm | input | 8 | Unsigned immediate |
| shiftAmt | input | 5 | Immediate left shift in bits |
| outValid | output | 1 | Result valid |
| outErr | output | 1 | Illegal operation flag, valid with outValid |
| result | output | 128 | Registered result |

## Verification
The hardest cases to reach are the illegal combinations: a 16-bit lane with a shift of 16 or 24, a shift that is not a byte multiple, and an immediate opcode paired with a byte arrangement. A uniform random draw over all inputs seldom produces them in a useful mix. Directed cases therefore pin each of these combinations. The random loop draws the shift mostly from byte multiples and sometimes from the full 5-bit range, so legal and illegal shifts are both common for each lane size.

// File: rtl/vec_logic_pkg.sv
package vec_logic_pkg;
  typedef enum logic [3:0] {
    OP_AND      = 4'd0,
    OP_OR       = 4'd1,
    OP_XOR      = 4'd2,
    OP_ANDNOT   = 4'd3,
    OP_ORNOT    = 4'd4,
    OP_INS_ZERO = 4'd5,
    OP_INS_ONE  = 4'd6,
    OP_SELECT   = 4'd7,
    OP_OR_IMM   = 4'd8,
    OP_CLR_IMM  = 4'd9
  } logicOp_e;

  typedef enum logic [2:0] {
    ARR_BYTE64  = 3'd0,
    ARR_BYTE128 = 3'd1,
    ARR_WORD64  = 3'd2,
    ARR_WORD128 = 3'd3,
    ARR_HALF64  = 3'd4,
    ARR_HALF128 = 3'd5
  } arrange_e;

  typedef struct packed {
    logic     load;
    logic     fault;
    logic     useImm;
    logic     narrow;
    logic     lane32;
    logic [1:0] shByte;
    logicOp_e op;
  } ctlStrobe_t;
endpackage

// File: rtl/vec_logic_ctrl.sv
module vec_logic_ctrl
  import vec_logic_pkg::*;
#(
  parameter int SHIFT_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [3:0]         opSel,
  input  logic [2:0]         arrSel,
  input  logic [SHIFT_W-1:0] shiftAmt,
  output ctlStrobe_t         ctl,
  output logic               outValid,
  output logic               outErr
);
  logic opKnown, opImm, arrKnown, arrByte, arrLane32, arrNarrow;
  logic shAligned, shInRange, fault;

  always_comb begin
    opKnown   = (opSel <= 4'd9);
    opImm     = (opSel == 4'd8) || (opSel == 4'd9);
    arrKnown  = (arrSel <= 3'd5);
    arrByte   = (arrSel == ARR_BYTE64) || (arrSel == ARR_BYTE128);
    arrLane32 = (arrSel == ARR_WORD64) || (arrSel == ARR_WORD128);
    arrNarrow = !arrSel[0];
    shAligned = (shiftAmt[2:0] == 3'd0);
    shInRange = arrLane32 ? 1'b1 : !shiftAmt[4];
    fault = !opKnown || !arrKnown ||
            (opImm && (arrByte || !shAligned || !shInRange));
  end

  always_comb begin
    ctl.load   = inValid;
    ctl.fault  = fault;
    ctl.useImm = opImm;
    ctl.narrow = arrNarrow;
    ctl.lane32 = arrLane32;
    ctl.shByte = shiftAmt[4:3];
    ctl.op     = opKnown ? logicOp_e'(opSel) : OP_AND;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outErr   <= 1'b0;
    end else begin
      outValid <= inValid;
      outErr   <= inValid && fault;
    end
  end
endmodule

// File: rtl/vec_imm_expand.sv
module vec_imm_expand #(
  parameter int DATA_W = 128,
  parameter int IMM_W  = 8
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic [1:0]        shByte,
  input  logic              lane32,
  output logic [DATA_W-1:0] pattern
);
  localparam int N32 = DATA_W / 32;
  localparam int N16 = DATA_W / 16;

  logic [31:0] word32;
  logic [15:0] word16;
  logic [DATA_W-1:0] rep32, rep16;

  always_comb begin
    word32 = 32'(imm) << {shByte, 3'b000};
    word16 = 16'(imm) << {shByte[0], 3'b000};
  end

  for (genvar i = 0; i < N32; i++) begin : g_lane32
    assign rep32[i*32 +: 32] = word32;
  end
  for (genvar j = 0; j < N16; j++) begin : g_lane16
    assign rep16[j*16 +: 16] = word16;
  end

  assign pattern = lane32 ? rep32 : rep16;
endmodule

// File: rtl/vec_logic_dp.sv
module vec_logic_dp
  import vec_logic_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  ctlStrobe_t        ctl,
  input  logic [DATA_W-1:0] srcDst,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] immPat, opRes, maskedRes, nextRes;

  vec_imm_expand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_expand (
    .imm    (imm),
    .shByte (ctl.shByte),
    .lane32 (ctl.lane32),
    .pattern(immPat)
  );

  always_comb begin
    unique case (ctl.op)
      OP_AND:      opRes = srcA & srcB;
      OP_OR:       opRes = srcA | srcB;
      OP_XOR:      opRes = srcA ^ srcB;
      OP_ANDNOT:   opRes = srcA & ~srcB;
      OP_ORNOT:    opRes = srcA | ~srcB;
      OP_INS_ZERO: opRes = (srcDst & srcB) | (srcA & ~srcB);
      OP_INS_ONE:  opRes = (srcDst & ~srcB) | (srcA & srcB);
      OP_SELECT:   opRes = (srcDst & srcA) | (~srcDst & srcB);
      OP_OR_IMM:   opRes = srcDst | immPat;
      OP_CLR_IMM:  opRes = srcDst & ~immPat;
      default:     opRes = srcDst;
    endcase
  end

  always_comb begin
    maskedRes = opRes;
    if (ctl.narrow) maskedRes[DATA_W-1:HALF_W] = '0;
    nextRes = ctl.fault ? srcDst : maskedRes;
  end

  always_ff @(posedge clk) begin
    if (ctl.load) result <= nextRes;
  end
endmodule

// File: rtl/vec_logic_unit.sv
module vec_logic_unit
  import vec_logic_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int IMM_W   = 8,
  parameter int SHIFT_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [3:0]         opSel,
  input  logic [2:0]         arrSel,
  input  logic [DATA_W-1:0]  srcDst,
  input  logic [DATA_W-1:0]  srcA,
  input  logic [DATA_W-1:0]  srcB,
  input  logic [IMM_W-1:0]   imm,
  input  logic [SHIFT_W-1:0] shiftAmt,
  output logic               outValid,
  output logic               outErr,
  output logic [DATA_W-1:0]  result
);
  ctlStrobe_t ctl;

  vec_logic_ctrl #(.SHIFT_W(SHIFT_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .opSel   (opSel),
    .arrSel  (arrSel),
    .shiftAmt(shiftAmt),
    .ctl     (ctl),
    .outValid(outValid),
    .outErr  (outErr)
  );

  vec_logic_dp #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dp (
    .clk   (clk),
    .ctl   (ctl),
    .srcDst(srcDst),
    .srcA  (srcA),
    .srcB  (srcB),
    .imm   (imm),
    .result(result)
  );
endmodule

// File: rtl/vec_logic_checker.sv
module vec_logic_checker (
  input logic         clk,
  input logic         rst,
  input logic         inValid,
  input logic [3:0]   opSel,
  input logic [2:0]   arrSel,
  input logic [127:0] srcDst,
  input logic [127:0] srcA,
  input logic [127:0] srcB,
  input logic [4:0]   shiftAmt,
  input logic         outValid,
  input logic         outErr,
  input logic [127:0] result
);
  a_r8_valid_latency: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (outValid == $past(inValid)));

  a_r8_err_needs_valid: assert property (@(posedge clk) disable iff (rst)
    outErr |-> outValid);

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(result));

  a_r1_and_wide: assert property (@(posedge clk) disable iff (rst)
    (inValid && opSel == 4'd0 && arrSel == 3'd1) |=> (result == $past(srcA & srcB)) && !outErr);

  a_r2_select_wide: assert property (@(posedge clk) disable iff (rst)
    (inValid && opSel == 4'd7 && arrSel == 3'd1) |=>
      (result == $past((srcDst & srcA) | (~srcDst & srcB))));

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (inValid && opSel <= 4'd7 && (arrSel == 3'd0 || arrSel == 3'd2 || arrSel == 3'd4)) |=>
      (result[127:64] == 64'd0));

  a_r5_half_bad_shift: assert property (@(posedge clk) disable iff (rst)
    (inValid && (opSel == 4'd8 || opSel == 4'd9) && (arrSel == 3'd4 || arrSel == 3'd5) &&
     shiftAmt[4]) |=> (outErr && result == $past(srcDst)));

  a_r6_misaligned: assert property (@(posedge clk) disable iff (rst)
    (inValid && (opSel == 4'd8 || opSel == 4'd9) && shiftAmt[2:0] != 3'd0) |=>
      (outErr && result == $past(srcDst)));

  a_r7_bad_opcode: assert property (@(posedge clk) disable iff (rst)
    (inValid && opSel >= 4'd10) |=> (outErr && result == $past(srcDst)));
endmodule

bind vec_logic_unit vec_logic_checker u_checker (
  .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel), .arrSel(arrSel),
  .srcDst(srcDst), .srcA(srcA), .srcB(srcB), .shiftAmt(shiftAmt),
  .outValid(outValid), .outErr(outErr), .result(result)
);

// File: tb/test_vec_logic_unit.sv
module test_vec_logic_unit;
  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic [3:0]   opSel;
  logic [2:0]   arrSel;
  logic [127:0] srcDst, srcA, srcB;
  logic [7:0]   imm;
  logic [4:0]   shiftAmt;
  logic         outValid, outErr;
  logic [127:0] result;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  vec_logic_unit i_vec_logic_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel), .arrSel(arrSel),
    .srcDst(srcDst), .srcA(srcA), .srcB(srcB), .imm(imm), .shiftAmt(shiftAmt),
    .outValid(outValid), .outErr(outErr), .result(result)
  );

  function automatic logic [128:0] model(input logic [3:0] op, input logic [2:0] arr,
      input logic [127:0] d, input logic [127:0] a, input logic [127:0] b,
      input logic [7:0] im, input logic [4:0] sh);
    logic [127:0] r, pat;
    logic bad;
    int lw;
    bad = 1'b0;
    r = d;
    pat = '0;
    if (arr > 3'd5 || op > 4'd9) bad = 1'b1;
    else if (op >= 4'd8) begin
      if (arr <= 3'd1) bad = 1'b1;
      else begin
        lw = (arr == 3'd2 || arr == 3'd3) ? 32 : 16;
        if ((int'(sh) % 8) != 0 || int'(sh) >= lw) bad = 1'b1;
        else begin
          for (int i = 0; i < 128 / lw; i++)
            pat = pat | ((128'(im) << sh) << (i * lw));
          r = (op == 4'd8) ? (d | pat) : (d & ~pat);
        end
      end
    end else begin
      case (op)
        4'd0: r = a & b;
        4'd1: r = a | b;
        4'd2: r = a ^ b;
        4'd3: r = a & ~b;
        4'd4: r = a | ~b;
        4'd5: r = (d & b) | (a & ~b);
        4'd6: r = (d & ~b) | (a & b);
        default: r = (d & a) | (~d & b);
      endcase
    end
    if (!bad && arr[0] == 1'b0) r[127:64] = '0;
    if (bad) r = d;
    return {bad, r};
  endfunction

  task automatic check(input string req, input logic ok, input logic [128:0] act,
                       input logic [128:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic apply(input string req, input logic [3:0] op, input logic [2:0] arr,
      input logic [127:0] d, input logic [127:0] a, input logic [127:0] b,
      input logic [7:0] im, input logic [4:0] sh, input logic idleCheck);
    logic [128:0] exp;
    logic [127:0] held;
    @(negedge clk);
    inValid = 1'b1; opSel = op; arrSel = arr;
    srcDst = d; srcA = a; srcB = b; imm = im; shiftAmt = sh;
    exp = model(op, arr, d, a, b, im, sh);
    @(negedge clk);
    inValid = 1'b0;
    srcDst = rnd128(); srcA = rnd128(); srcB = rnd128();
    check(req, outValid === 1'b1 && {outErr, result} === exp, {outValid, outErr, result}, exp);
    if (idleCheck) begin
      held = result;
      @(negedge clk);
      check({req, " R8 idle"}, outValid === 1'b0 && outErr === 1'b0 && result === held,
            {outValid, result}, {1'b0, held});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] pd, pa, pb;
    void'($urandom(32'd2718));
    rst = 1'b1; inValid = 1'b0; opSel = '0; arrSel = '0;
    srcDst = '0; srcA = '0; srcB = '0; imm = '0; shiftAmt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset", outValid === 1'b0 && outErr === 1'b0, {outValid, outErr}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 idle after reset", outValid === 1'b0, outValid, '0);

    pd = 128'hF0F0_F0F0_0F0F_0F0F_AAAA_5555_FFFF_0000;
    pa = 128'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321;
    pb = 128'hFF00_FF00_00FF_00FF_F0F0_0F0F_CCCC_3333;

    apply("R1 and wide",   4'd0, 3'd1, pd, pa, pb, 8'h00, 5'd0, 1'b1);
    apply("R1 xor wide",   4'd2, 3'd3, pd, pa, pb, 8'h00, 5'd0, 1'b0);
    apply("R1 andnot",     4'd3, 3'd5, pd, pa, pb, 8'h00, 5'd0, 1'b0);
    apply("R1 ornot",      4'd4, 3'd1, pd, pa, pb, 8'h00, 5'd0, 1'b0);
    apply("R2 insert-zero",4'd5, 3'd1, pd, pa, pb, 8'h00, 5'd0, 1'b0);
    apply("R2 insert-one", 4'd6, 3'd1, pd, pa, pb, 8'h00, 5'd0, 1'b0);
    apply("R2 select",     4'd7, 3'd1, pd, pa, pb, 8'h00, 5'd0, 1'b0);
    apply("R3 or narrow",  4'd1, 3'd0, pd, pa, pb, 8'h00, 5'd0, 1'b0);
    apply("R3 ornot narrow", 4'd4, 3'd2, pd, '0, '0, 8'h00, 5'd0, 1'b0);
    apply("R4 or imm w32 sh24", 4'd8, 3'd3, '0, pa, pb, 8'hA5, 5'd24, 1'b1);
    apply("R4 clr imm w32 sh16 narrow", 4'd9, 3'd2, '1, pa, pb, 8'h81, 5'd16, 1'b0);
    apply("R5 or imm h16 sh8", 4'd8, 3'd5, '0, pa, pb, 8'h3C, 5'd8, 1'b0);
    apply("R5 clr imm h16 sh0", 4'd9, 3'd5, '1, pa, pb, 8'hFF, 5'd0, 1'b0);
    apply("R6 h16 sh16", 4'd8, 3'd5, pd, pa, pb, 8'hFF, 5'd16, 1'b1);
    apply("R6 h16 sh24 narrow", 4'd9, 3'd4, pd, pa, pb, 8'hFF, 5'd24, 1'b0);
    apply("R6 w32 sh4", 4'd8, 3'd3, pd, pa, pb, 8'h11, 5'd4, 1'b0);
    apply("R7 imm byte arr", 4'd8, 3'd1, pd, pa, pb, 8'h11, 5'd0, 1'b0);
    apply("R7 opcode 12", 4'd12, 3'd1, pd, pa, pb, 8'h11, 5'd0, 1'b0);
    apply("R7 arrangement 7", 4'd0, 3'd7, pd, pa, pb, 8'h11, 5'd0, 1'b0);

    for (int n = 0; n < 3000; n++) begin
      logic [4:0] sh;
      sh = ($urandom() % 4 == 0) ? 5'($urandom()) : 5'(($urandom() % 4) * 8);
      apply("random", 4'($urandom() % 11), 3'($urandom() % 7), rnd128(), rnd128(),
            rnd128(), 8'($urandom()), sh, ($urandom() % 8) == 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule